// File: doc/BRIEF.md
# Bit-Addressable Card Control and Status Register

This block is a 16-bit control and status register for a processor card on a shared peripheral bus. The host addresses each register bit individually. A write carries a bit index and a one-bit value, and changes only the selected bit. A read returns all sixteen bits on the low half of a 32-bit data bus.

The register bits have different owners. Some bits are set and cleared only by software. One is set by software and cleared by hardware when the request is acknowledged. Two are fault flags that hardware sets and software clears. Each bit drives one line toward the card processor or the system processor:

- three leveled interrupts to the card,
- a non-maskable interrupt request to the card,
- an interrupt back to the system processor,
- a halt line that keeps the card processor quiescent,
- a software reset line for the card processor.

Two synchronous reset inputs act on different groups of bits: a host power-up reset and a card reset. Bit positions are fixed because host software decodes them. All updates take effect at the clock edge that samples the request. The outputs and the read data follow the stored bits directly.

Top module: `pcsr_ctl_reg`

## Requirements
- R1: `rd_data[15:0]` shows the register bits in the cycle after any update. `rd_data[31:16]` and the reserved bits carry no defined value (the model drives 0).
- R2: A write with `wr_en`=1 loads `wr_val` into bit `wr_addr` at the next clock edge. Every other bit keeps its value.
- R3: Bits 15, 14 and 13 are software read/write bits that are cleared only by power-up reset. They drive `irq_lvl10`, `irq_lvl12` and `irq_lvl15` respectively.
- R4: Bit 12 drives `nmi_req`. Software sets it. A pulse on `nmi_ack` clears it one cycle later. A software write of 1 in the same cycle as the acknowledge wins.
- R5: Bit 11 is set by `align_fault` and cleared by a software write of 0. If the fault and a software clear arrive in the same cycle, the bit ends up set.
- R6: Bit 3 is set by `membus_fault` and cleared by a software write of 0. If the fault and a software clear arrive in the same cycle, the bit ends up set.
- R7: Bit 2 is a software read/write bit that drives `sys_irq15`. Card reset clears it.
- R8: Bit 1 drives `halt_req`. Card reset and power-up reset force it to 1. Software may set it or clear it.
- R9: Bit 0 is a software read/write bit that drives `cpu_reset_req`. Power-up reset clears it. Card reset leaves it unchanged.
- R10: Writes to bits 10 down to 4 have no effect on any bit or output. Those bits read as 0 in the model.
- R11: After power-up reset the low half of the register reads `16'h0002`: halt is set and every other bit is 0, including the fault flags.
- R12: Power-up reset overrides everything else. Card reset overrides a software write to bits 2 and 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst | input | 1 | Synchronous host power-up reset, active high |
| card_rst | input | 1 | Synchronous card reset, active high |
| wr_en | input | 1 | Single-bit write strobe |
| wr_addr | input | ADDR_W (4) | Index of the bit to write |
| wr_val | input | 1 | Value written to the selected bit |
| rd_data | output | DATA_W (32) | Register contents on the low half |
| nmi_ack | input | 1 | Card processor acknowledge of the non-maskable interrupt |
| align_fault | input | 1 | Alignment fault pulse from the card processor |
| membus_fault | input | 1 | Fault pulse from a main-memory access |
| irq_lvl10 | output | 1 | Level-10 interrupt to the card processor |
| irq_lvl12 | output | 1 | Level-12 interrupt to the card processor |
| irq_lvl15 | output | 1 | Level-15 interrupt to the card processor |
| nmi_req | output | 1 | Non-maskable interrupt request to the card processor |
| sys_irq15 | output | 1 | Level-15 interrupt to the system processor |
| halt_req | output | 1 | Halt/quiesce request to the card processor |
| cpu_reset_req | output | 1 | Software reset to the card processor |

## Verification
The bound checker watches these rules on every cycle:

- the interrupt lines match their register bits,
- the reserved field stays at zero,
- software-only bits stay stable when no write is made,
- the reset bit is unaffected by card reset,
- a fault pulse always leaves its flag set,
- an acknowledge without a competing write clears the interrupt request,
- the register value right after power-up reset is correct.

Only the bench scenarios show that whole sequences of single-bit writes build the right register word, and that the tie-break rules hold. Those rules are: a fault beats a same-cycle clear, a write beats a same-cycle acknowledge, and card reset beats a same-cycle write.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;

   // Ownership class of one register bit
   typedef enum logic [2:0] {
      BK_RSVD,       // no storage, reads 0
      BK_SW,         // software set/clear, power-up reset clears
      BK_SW_HWCLR,   // software set, hardware acknowledge clears
      BK_HW_SWCLR,   // hardware set, software clear, hardware wins
      BK_CARD_CLR,   // software set/clear, card reset clears
      BK_CARD_SET    // software set/clear, card reset sets
   } bit_kind_e;

   // Bit positions decoded by host software
   localparam int unsigned IDX_IRQ10  = 15;
   localparam int unsigned IDX_IRQ12  = 14;
   localparam int unsigned IDX_IRQ15  = 13;
   localparam int unsigned IDX_NMI    = 12;
   localparam int unsigned IDX_ALIGN  = 11;
   localparam int unsigned IDX_MEMERR = 3;
   localparam int unsigned IDX_SYSIRQ = 2;
   localparam int unsigned IDX_HALT   = 1;
   localparam int unsigned IDX_CPURST = 0;

   function automatic bit_kind_e kind_of(input int unsigned idx);
      case (idx)
         IDX_IRQ10, IDX_IRQ12, IDX_IRQ15, IDX_CPURST: return BK_SW;
         IDX_NMI:                                    return BK_SW_HWCLR;
         IDX_ALIGN, IDX_MEMERR:                      return BK_HW_SWCLR;
         IDX_SYSIRQ:                                 return BK_CARD_CLR;
         IDX_HALT:                                   return BK_CARD_SET;
         default:                                    return BK_RSVD;
      endcase
   endfunction

endpackage

// File: rtl/pcsr_addr_match.sv
module pcsr_addr_match #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned IDX    = 0
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              hit
);
   if (IDX >= (1 << ADDR_W)) begin : g_bad_idx
      $error("pcsr_addr_match: IDX does not fit in ADDR_W");
   end

   assign hit = wr_en && (wr_addr == ADDR_W'(IDX));
endmodule

// File: rtl/pcsr_bit_cell.sv
module pcsr_bit_cell #(
   parameter pcsr_pkg::bit_kind_e KIND = pcsr_pkg::BK_SW
) (
   input  logic clk,
   input  logic pwr_rst,
   input  logic card_rst,
   input  logic wr_hit,
   input  logic wr_val,
   input  logic hw_set,
   input  logic hw_clr,
   output logic q
);
   import pcsr_pkg::*;

   localparam logic RST_VAL  = (KIND == BK_CARD_SET);
   localparam logic CARD_DOM = (KIND == BK_CARD_CLR) || (KIND == BK_CARD_SET);

   if (KIND == BK_RSVD) begin : g_bad_kind
      $error("pcsr_bit_cell: reserved bits carry no storage cell");
   end

   // Priority: power-up reset, card reset (own domain), hardware set,
   // software write, hardware clear
   always_ff @(posedge clk) begin
      if (pwr_rst)                 q <= RST_VAL;
      else if (CARD_DOM && card_rst) q <= RST_VAL;
      else if (hw_set)             q <= 1'b1;
      else if (wr_hit)             q <= wr_val;
      else if (hw_clr)             q <= 1'b0;
   end
endmodule

// File: rtl/pcsr_rd_pack.sv
module pcsr_rd_pack #(
   parameter int unsigned REG_W  = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic [REG_W-1:0]  bits,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W > REG_W) begin : g_wide
      assign rd_data = {{(DATA_W-REG_W){1'b0}}, bits};
   end else begin : g_exact
      assign rd_data = bits;
   end
endmodule

// File: rtl/pcsr_ctl_reg.sv
module pcsr_ctl_reg #(
   parameter  int unsigned REG_W  = 16,
   parameter  int unsigned DATA_W = 32,
   localparam int unsigned ADDR_W = $clog2(REG_W)
) (
   input  logic              clk,
   input  logic              pwr_rst,
   input  logic              card_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_val,
   output logic [DATA_W-1:0] rd_data,
   input  logic              nmi_ack,
   input  logic              align_fault,
   input  logic              membus_fault,
   output logic              irq_lvl10,
   output logic              irq_lvl12,
   output logic              irq_lvl15,
   output logic              nmi_req,
   output logic              sys_irq15,
   output logic              halt_req,
   output logic              cpu_reset_req
);
   import pcsr_pkg::*;

   if (REG_W != 16) begin : g_bad_reg_w
      $error("pcsr_ctl_reg: bit map is defined for a 16-bit register");
   end
   if (DATA_W < REG_W) begin : g_bad_data_w
      $error("pcsr_ctl_reg: data bus narrower than register");
   end

   logic [REG_W-1:0] bits;

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      localparam bit_kind_e KIND = kind_of(i);
      if (KIND == BK_RSVD) begin : g_rsvd
         assign bits[i] = 1'b0;
      end else begin : g_cell
         logic hit, hs, hc;

         pcsr_addr_match #(.ADDR_W(ADDR_W), .IDX(i)) u_match (
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .hit     (hit)
         );

         assign hs = (i == IDX_ALIGN)  ? align_fault  :
                     (i == IDX_MEMERR) ? membus_fault : 1'b0;
         assign hc = (i == IDX_NMI)    ? nmi_ack      : 1'b0;

         pcsr_bit_cell #(.KIND(KIND)) u_cell (
            .clk      (clk),
            .pwr_rst  (pwr_rst),
            .card_rst (card_rst),
            .wr_hit   (hit),
            .wr_val   (wr_val),
            .hw_set   (hs),
            .hw_clr   (hc),
            .q        (bits[i])
         );
      end
   end

   pcsr_rd_pack #(.REG_W(REG_W), .DATA_W(DATA_W)) u_rd (
      .bits    (bits),
      .rd_data (rd_data)
   );

   assign irq_lvl10     = bits[IDX_IRQ10];
   assign irq_lvl12     = bits[IDX_IRQ12];
   assign irq_lvl15     = bits[IDX_IRQ15];
   assign nmi_req       = bits[IDX_NMI];
   assign sys_irq15     = bits[IDX_SYSIRQ];
   assign halt_req      = bits[IDX_HALT];
   assign cpu_reset_req = bits[IDX_CPURST];
endmodule

// File: rtl/pcsr_ctl_reg_chk.sv
module pcsr_ctl_reg_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              pwr_rst,
   input logic              card_rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_val,
   input logic [DATA_W-1:0] rd_data,
   input logic              nmi_ack,
   input logic              align_fault,
   input logic              membus_fault,
   input logic              irq_lvl10,
   input logic              irq_lvl12,
   input logic              irq_lvl15,
   input logic              nmi_req,
   input logic              sys_irq15,
   input logic              halt_req,
   input logic              cpu_reset_req
);
   logic nmi_wr1, cpurst_wr;
   assign nmi_wr1   = wr_en && (wr_addr == ADDR_W'(12)) && wr_val;
   assign cpurst_wr = wr_en && (wr_addr == ADDR_W'(0));

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (pwr_rst)
      rd_data[DATA_W-1:16] == '0);                                       // R1
   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (pwr_rst)
      wr_en && (wr_addr == ADDR_W'(15)) |=> irq_lvl10 == $past(wr_val));  // R2
   AST_SW_ONLY_STABLE: assert property (@(posedge clk) disable iff (pwr_rst)
      !wr_en |=> $stable(rd_data[15:13]));                                // R2
   AST_IRQ_MAP: assert property (@(posedge clk) disable iff (pwr_rst)
      {irq_lvl10, irq_lvl12, irq_lvl15} == rd_data[15:13]);               // R3
   AST_NMI_ACK_CLEARS: assert property (@(posedge clk) disable iff (pwr_rst)
      nmi_ack && !nmi_wr1 |=> !nmi_req);                                  // R4
   AST_ALIGN_SETS: assert property (@(posedge clk) disable iff (pwr_rst)
      align_fault |=> rd_data[11]);                                       // R5
   AST_MEMERR_SETS: assert property (@(posedge clk) disable iff (pwr_rst)
      membus_fault |=> rd_data[3]);                                       // R6
   AST_CARD_RST_CLEARS: assert property (@(posedge clk) disable iff (pwr_rst)
      card_rst |=> !sys_irq15);                                           // R7
   AST_CARD_RST_HALTS: assert property (@(posedge clk) disable iff (pwr_rst)
      card_rst |=> halt_req);                                             // R8
   AST_CPURST_KEEPS: assert property (@(posedge clk) disable iff (pwr_rst)
      card_rst && !cpurst_wr |=> $stable(cpu_reset_req));                 // R9
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (pwr_rst)
      rd_data[10:4] == '0);                                               // R10
   AST_PWR_VALUE: assert property (@(posedge clk) disable iff (pwr_rst)
      $fell(pwr_rst) |-> rd_data[15:0] == 16'h0002);                      // R11
endmodule

bind pcsr_ctl_reg pcsr_ctl_reg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .pwr_rst       (pwr_rst),
   .card_rst      (card_rst),
   .wr_en         (wr_en),
   .wr_addr       (wr_addr),
   .wr_val        (wr_val),
   .rd_data       (rd_data),
   .nmi_ack       (nmi_ack),
   .align_fault   (align_fault),
   .membus_fault  (membus_fault),
   .irq_lvl10     (irq_lvl10),
   .irq_lvl12     (irq_lvl12),
   .irq_lvl15     (irq_lvl15),
   .nmi_req       (nmi_req),
   .sys_irq15     (sys_irq15),
   .halt_req      (halt_req),
   .cpu_reset_req (cpu_reset_req)
);

// File: tb/pcsr_ctl_reg_bench.sv
module pcsr_ctl_reg_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] MASK = 16'hF80F;  // defined bits only

   logic        clk = 1'b0;
   logic        pwr_rst = 1'b1, card_rst = 1'b0;
   logic        wr_en = 1'b0, wr_val = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic        nmi_ack = 1'b0, align_fault = 1'b0, membus_fault = 1'b0;
   logic [31:0] rd_data;
   logic irq_lvl10, irq_lvl12, irq_lvl15, nmi_req, sys_irq15, halt_req, cpu_reset_req;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcsr_ctl_reg u_pcsr_ctl_reg (
      .clk(clk), .pwr_rst(pwr_rst), .card_rst(card_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_val(wr_val), .rd_data(rd_data),
      .nmi_ack(nmi_ack), .align_fault(align_fault), .membus_fault(membus_fault),
      .irq_lvl10(irq_lvl10), .irq_lvl12(irq_lvl12), .irq_lvl15(irq_lvl15),
      .nmi_req(nmi_req), .sys_irq15(sys_irq15), .halt_req(halt_req),
      .cpu_reset_req(cpu_reset_req)
   );

   // {bit index, value, expected low half after the write}
   localparam logic [20:0] VEC [0:11] = '{
      {4'd15, 1'b1, 16'h8002},
      {4'd13, 1'b1, 16'hA002},
      {4'd0,  1'b1, 16'hA003},
      {4'd2,  1'b1, 16'hA007},
      {4'd7,  1'b1, 16'hA007},
      {4'd1,  1'b0, 16'hA005},
      {4'd12, 1'b1, 16'hB005},
      {4'd14, 1'b1, 16'hF005},
      {4'd15, 1'b0, 16'h7005},
      {4'd0,  1'b0, 16'h7004},
      {4'd1,  1'b1, 16'h7006},
      {4'd4,  1'b1, 16'h7006}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Compare defined register bits and every output line against one word
   task automatic check_word(input string req, input logic [15:0] exp);
      logic [15:0] outs, eouts;
      check(req, rd_data[15:0] & MASK, exp & MASK);
      outs  = {9'd0, irq_lvl10, irq_lvl12, irq_lvl15, nmi_req, sys_irq15, halt_req, cpu_reset_req};
      eouts = {9'd0, exp[15], exp[14], exp[13], exp[12], exp[2], exp[1], exp[0]};
      check({req, " outputs"}, outs, eouts);
   endtask

   // One clock of stimulus: drive after negedge, sample at next negedge
   task automatic cyc(input logic we, input logic [3:0] a, input logic v,
                      input logic ack, input logic af, input logic mf,
                      input logic crst, input logic prst);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_val = v; nmi_ack = ack;
      align_fault = af; membus_fault = mf; card_rst = crst; pwr_rst = prst;
      @(negedge clk);
      wr_en = 1'b0; nmi_ack = 1'b0; align_fault = 1'b0; membus_fault = 1'b0;
      card_rst = 1'b0; pwr_rst = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      pwr_rst = 1'b0;
      @(negedge clk);
      check_word("R11 power-up value", 16'h0002);

      // R2 R3 R7 R8 R9 R10: single-bit write sequence
      foreach (VEC[k]) begin
         cyc(1'b1, VEC[k][20:17], VEC[k][16], 0, 0, 0, 0, 0);
         check_word("R2 table write", VEC[k][15:0]);
      end

      // R4 acknowledge clears, write of 1 wins over same-cycle acknowledge
      cyc(0, 4'd0, 0, 1, 0, 0, 0, 0);       check_word("R4 ack clears", 16'h6006);
      cyc(1, 4'd12, 1, 1, 0, 0, 0, 0);      check_word("R4 write beats ack", 16'h7006);

      // R5 alignment flag
      cyc(0, 4'd0, 0, 0, 1, 0, 0, 0);       check_word("R5 fault sets", 16'h7806);
      cyc(1, 4'd11, 0, 0, 0, 0, 0, 0);      check_word("R5 sw clear", 16'h7006);
      cyc(1, 4'd11, 0, 0, 1, 0, 0, 0);      check_word("R5 fault beats clear", 16'h7806);
      cyc(1, 4'd11, 0, 0, 0, 0, 0, 0);      check_word("R5 sw clear again", 16'h7006);

      // R6 memory fault flag
      cyc(0, 4'd0, 0, 0, 0, 1, 0, 0);       check_word("R6 fault sets", 16'h700E);
      cyc(1, 4'd3, 0, 0, 0, 1, 0, 0);       check_word("R6 fault beats clear", 16'h700E);
      cyc(1, 4'd3, 0, 0, 0, 0, 0, 0);       check_word("R6 sw clear", 16'h7006);

      // R9 R8 R12: card reset domain
      cyc(1, 4'd0, 1, 0, 0, 0, 0, 0);       check_word("R9 set reset bit", 16'h7007);
      cyc(1, 4'd1, 0, 0, 0, 0, 0, 0);       check_word("R8 clear halt", 16'h7005);
      cyc(1, 4'd2, 0, 0, 0, 0, 0, 0);       check_word("R7 clear sys irq", 16'h7001);
      cyc(1, 4'd2, 1, 0, 0, 0, 1, 0);       check_word("R12 card reset beats write", 16'h7003);
      cyc(1, 4'd2, 1, 0, 0, 0, 0, 0);       check_word("R7 set sys irq", 16'h7007);
      cyc(0, 4'd0, 0, 0, 0, 0, 1, 0);       check_word("R7 card reset clears", 16'h7003);

      // R10 reserved write leaves everything alone
      cyc(1, 4'd10, 1, 0, 0, 0, 0, 0);      check_word("R10 reserved write", 16'h7003);

      // R11 R12 power-up reset mid-run overrides a write
      cyc(1, 4'd15, 1, 0, 0, 0, 0, 1);      check_word("R11 power reset", 16'h0002);

      // R1 read tracks the register right after update
      cyc(1, 4'd14, 1, 0, 0, 0, 0, 0);      check_word("R1 read after write", 16'h4002);

      finish_run();
   end
endmodule